// File: doc/BRIEF.md
# Rational-Rate Nanosecond Timer with Alarm

This block keeps a 56-bit time count that advances by a programmable fraction, numerator over denominator, on every core clock. With suitable rate values the count runs in nanoseconds at any clock frequency. The fraction is exact over the long run. A remainder accumulator carries the part of a unit left over in one clock into the next, so after n clocks from a clean start the count has grown by floor(n * numerator / denominator).

The count is held as a 29-bit low word and a 27-bit high word. The low word carries into the high word when it wraps. The low word alone is watched against a 29-bit alarm value. Because one step may add many units at once, the alarm fires when the low word passes the alarm value, not only when it lands on it. The event is latched into a status bit, and the interrupt output is that bit gated by an enable bit. Software talks to the block through a single-cycle register port. Writes take effect at the next clock edge, and reads return the addressed register combinationally in the same cycle.

Register offsets, relative to the block: 0x100 status (bit 0: alarm seen), 0x140 enable (bit 0), 0x200 numerator (bits 15:0), 0x210 denominator (bits 15:0), 0x400 high time word (bits 31:5), 0x410 low time word (bits 28:0), 0x420 alarm (bits 28:0). Unused bits read as zero.

Top module: `rtmr_top`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: After the denominator is written, n further clocks with no other write add exactly floor(n*num/den) to the 56-bit count. The advance can be several units per clock.
- R3: When the low word wraps past 2^29-1, the high word increases by one. The high word reads back in bits 31:5 of its register, and the low word reads back in bits 28:0 of its register.
- R4: While the denominator is zero, the count does not change.
- R5: An alarm event occurs on a clock whose advance moves the low word from below the alarm value to at-or-above it. A wrap counts too: the event occurs if the old value was below the alarm or the new value is at-or-above it. Each crossing gives one event.
- R6: Status bit 0 is set by an alarm event and holds until software writes 1 to bit 0 of the status register. A write of 1 clears the bit.
- R7: If an alarm event and a status clear fall in the same clock, the status bit stays set.
- R8: The interrupt output is high exactly when both the status bit and the enable bit are set. The status bit is still latched while the enable bit is clear.
- R9: A write to either time word loads that word at the next clock, and the count does not advance in that clock.
- R10: A write to the numerator or the denominator clears the remainder accumulator, and the count does not advance in that clock.
- R11: The numerator, denominator, enable and alarm registers read back what was written, limited to their field widths.
- R12: The high word never takes part in the alarm comparison. Changing the high word alone raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 12 | Block-relative register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Alarm interrupt, status AND enable |

## Verification
The two functions that can fall in the same clock are an alarm crossing and a software clear of the status bit. To provoke the collision, the bench parks the low word one below the alarm value at a rate of one unit per clock. It then places the write-1 to status exactly on the edge that takes the low word onto the alarm value. The result is judged by reading the status register afterwards: it must still read 1. A second collision places a time-word write on a running count, and the bench checks that the loaded value is seen unchanged, with no extra increment.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int RATE_W = 16;
  localparam int LO_W   = 29;
  localparam int HI_W   = 27;
  localparam int HI_LSB = DATA_W - HI_W;
  localparam int CNT_W  = LO_W + HI_W;
  localparam int STEP_W = RATE_W + 1;

  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 12'h140;
  localparam logic [ADDR_W-1:0] OFF_NUM  = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_DEN  = 12'h210;
  localparam logic [ADDR_W-1:0] OFF_THI  = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_TLO  = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_ALM  = 12'h420;

  // Whole units and leftover of (accumulator + numerator) / denominator.
  // A zero denominator yields no units and an empty remainder.
  function automatic logic [2*STEP_W-1:0] rate_div(input logic [STEP_W-1:0] sum,
                                                    input logic [RATE_W-1:0] den);
    logic [STEP_W-1:0] q, r;
    if (den == '0) begin
      q = '0;
      r = '0;
    end else begin
      q = sum / {1'b0, den};
      r = sum % {1'b0, den};
    end
    return {q, r};
  endfunction

  // True when moving from prev to nxt passes the mark (wrap aware).
  function automatic logic crossed(input logic [LO_W-1:0] prev,
                                   input logic [LO_W-1:0] nxt,
                                   input logic [LO_W-1:0] mark);
    if (nxt < prev) return (prev < mark) || (nxt >= mark);
    return (prev < mark) && (nxt >= mark);
  endfunction
endpackage

// File: rtl/rtmr_rate.sv
module rtmr_rate #(
  parameter int RATE_W = rtmr_pkg::RATE_W,
  localparam int STEP_W = RATE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] num,
  input  logic [RATE_W-1:0] den,
  input  logic              adv_en,
  input  logic              rate_wr,
  output logic [STEP_W-1:0] step
);
  logic [STEP_W-1:0] acc, sum, quot, rem;

  always_comb begin
    sum         = acc + {1'b0, num};
    {quot, rem} = rtmr_pkg::rate_div(sum, den);
    step        = adv_en ? quot : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (rate_wr) acc <= '0;
    else if (adv_en)  acc <= rem;
  end
endmodule

// File: rtl/rtmr_count.sv
module rtmr_count #(
  parameter int LO_W   = rtmr_pkg::LO_W,
  parameter int HI_W   = rtmr_pkg::HI_W,
  parameter int STEP_W = rtmr_pkg::STEP_W,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [LO_W-1:0]   lo_val,
  input  logic [HI_W-1:0]   hi_val,
  output logic [HI_W-1:0]   hi,
  output logic [LO_W-1:0]   lo,
  output logic [LO_W-1:0]   lo_nxt
);
  logic [HI_W-1:0]  hi_nxt;
  logic [CNT_W-1:0] sum;

  always_comb begin
    sum = {hi, lo} + {{(CNT_W-STEP_W){1'b0}}, step};
    {hi_nxt, lo_nxt} = sum;
    if (lo_wr) begin
      lo_nxt = lo_val;
      hi_nxt = hi;
    end else if (hi_wr) begin
      lo_nxt = lo;
      hi_nxt = hi_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
    end else begin
      hi <= hi_nxt;
      lo <= lo_nxt;
    end
  end
endmodule

// File: rtl/rtmr_alarm.sv
module rtmr_alarm #(
  parameter int LO_W = rtmr_pkg::LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LO_W-1:0] lo,
  input  logic [LO_W-1:0] lo_nxt,
  input  logic [LO_W-1:0] mark,
  input  logic            adv_en,
  input  logic            stat_clr,
  input  logic            irq_en,
  output logic            evt,
  output logic            stat,
  output logic            irq
);
  assign evt = adv_en && rtmr_pkg::crossed(lo, lo_nxt, mark);
  assign irq = stat && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n)        stat <= 1'b0;
    else if (evt)      stat <= 1'b1;
    else if (stat_clr) stat <= 1'b0;
  end
endmodule

// File: rtl/rtmr_top.sv
module rtmr_top
  import rtmr_pkg::*;
#(
  parameter int DW = rtmr_pkg::DATA_W,
  parameter int AW = rtmr_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic              num_wr, den_wr, lo_wr, hi_wr, ien_wr, alm_wr, stat_clr;
  logic              rate_wr, time_wr, adv_en;
  logic [RATE_W-1:0] num_q, den_q;
  logic [LO_W-1:0]   alm_q;
  logic              ien_q;
  logic [STEP_W-1:0] step;
  logic [HI_W-1:0]   hi;
  logic [LO_W-1:0]   lo, lo_nxt;
  logic              evt, stat;

  assign num_wr   = bus_we && (bus_addr == OFF_NUM);
  assign den_wr   = bus_we && (bus_addr == OFF_DEN);
  assign lo_wr    = bus_we && (bus_addr == OFF_TLO);
  assign hi_wr    = bus_we && (bus_addr == OFF_THI);
  assign ien_wr   = bus_we && (bus_addr == OFF_IEN);
  assign alm_wr   = bus_we && (bus_addr == OFF_ALM);
  assign stat_clr = bus_we && (bus_addr == OFF_STAT) && bus_wdata[0];
  assign rate_wr  = num_wr || den_wr;
  assign time_wr  = lo_wr || hi_wr;
  assign adv_en   = !(rate_wr || time_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
      alm_q <= '0;
      ien_q <= 1'b0;
    end else begin
      if (num_wr) num_q <= bus_wdata[RATE_W-1:0];
      if (den_wr) den_q <= bus_wdata[RATE_W-1:0];
      if (alm_wr) alm_q <= bus_wdata[LO_W-1:0];
      if (ien_wr) ien_q <= bus_wdata[0];
    end
  end

  rtmr_rate #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .num(num_q), .den(den_q),
    .adv_en(adv_en), .rate_wr(rate_wr), .step(step)
  );

  rtmr_count #(.LO_W(LO_W), .HI_W(HI_W), .STEP_W(STEP_W)) u_count (
    .clk(clk), .rst_n(rst_n), .step(step), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .lo_val(bus_wdata[LO_W-1:0]), .hi_val(bus_wdata[DW-1:HI_LSB]),
    .hi(hi), .lo(lo), .lo_nxt(lo_nxt)
  );

  rtmr_alarm #(.LO_W(LO_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .lo(lo), .lo_nxt(lo_nxt), .mark(alm_q),
    .adv_en(adv_en), .stat_clr(stat_clr), .irq_en(ien_q),
    .evt(evt), .stat(stat), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_STAT: bus_rdata[0] = stat;
      OFF_IEN:  bus_rdata[0] = ien_q;
      OFF_NUM:  bus_rdata[RATE_W-1:0] = num_q;
      OFF_DEN:  bus_rdata[RATE_W-1:0] = den_q;
      OFF_THI:  bus_rdata[DW-1:HI_LSB] = hi;
      OFF_TLO:  bus_rdata[LO_W-1:0] = lo;
      OFF_ALM:  bus_rdata[LO_W-1:0] = alm_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtmr_chk.sv
module rtmr_chk #(
  parameter int LO_W   = rtmr_pkg::LO_W,
  parameter int HI_W   = rtmr_pkg::HI_W,
  parameter int RATE_W = rtmr_pkg::RATE_W,
  parameter int STEP_W = rtmr_pkg::STEP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] den,
  input logic [HI_W-1:0]   hi,
  input logic [LO_W-1:0]   lo,
  input logic [LO_W-1:0]   lo_val,
  input logic              lo_wr,
  input logic              time_wr,
  input logic [STEP_W-1:0] step,
  input logic              evt,
  input logic              stat,
  input logic              stat_clr
);
  a_r4_den_zero_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (den == '0 && !time_wr) |=> ({hi, lo} == $past({hi, lo})));

  a_r3_hi_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !time_wr |=> (hi == $past(hi)) || (lo < $past(lo)));

  a_r9_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (lo == $past(lo_val)));

  a_r5_evt_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (step != '0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !stat_clr) |=> stat);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> stat);
endmodule

bind rtmr_top rtmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .den(den_q), .hi(hi), .lo(lo),
  .lo_val(bus_wdata[rtmr_pkg::LO_W-1:0]), .lo_wr(lo_wr), .time_wr(time_wr),
  .step(step), .evt(evt), .stat(stat), .stat_clr(stat_clr)
);

// File: tb/rtmr_top_tb_top.sv
module rtmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam int NV = 9;
  localparam int V_NUM[NV]   = '{1, 3, 5, 0, 7, 65535, 2, 65535, 40000};
  localparam int V_DEN[NV]   = '{1, 7, 2, 5, 0, 1, 3, 65535, 65535};
  localparam int V_START[NV] = '{0, 100, 0, 7, 50, 0, 0, 0, 0};
  localparam int V_CYC[NV]   = '{10, 14, 9, 20, 10, 4, 10, 12, 50};
  localparam int V_ADV[NV]   = '{10, 6, 22, 0, 0, 262140, 6, 12, 30};

  localparam logic [11:0] A_STAT = 12'h100, A_IEN = 12'h140, A_NUM = 12'h200,
                          A_DEN = 12'h210, A_THI = 12'h400, A_TLO = 12'h410,
                          A_ALM = 12'h420;
  localparam logic [31:0] LO_MAX = 32'h1FFF_FFFF;

  rtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    run(3);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 status", A_STAT, 0);
    chk_reg("R1 enable", A_IEN, 0);
    chk_reg("R1 num", A_NUM, 0);
    chk_reg("R1 den", A_DEN, 0);
    chk_reg("R1 hi", A_THI, 0);
    chk_reg("R1 lo", A_TLO, 0);
    chk_reg("R1 alarm", A_ALM, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 / R4 rate table
    for (int i = 0; i < NV; i++) begin
      wr(A_DEN, 0);
      wr(A_TLO, V_START[i]);
      wr(A_THI, 0);
      wr(A_NUM, V_NUM[i]);
      wr(A_DEN, V_DEN[i]);
      run(V_CYC[i]);
      chk((V_DEN[i] == 0) ? "R4 den zero freeze" : "R2 rate advance",
          bus_rdata & 0, 0);
      chk_reg((V_DEN[i] == 0) ? "R4 lo" : "R2 lo", A_TLO, V_START[i] + V_ADV[i]);
    end

    // R11 field widths on read back
    wr(A_DEN, 0);
    wr(A_NUM, 32'hABCD_1234);
    chk_reg("R11 num", A_NUM, 32'h0000_1234);
    wr(A_ALM, 32'hFFFF_FFFF);
    chk_reg("R11 alarm", A_ALM, LO_MAX);
    wr(A_IEN, 32'hFFFF_FFFF);
    chk_reg("R11 enable", A_IEN, 1);
    wr(A_IEN, 0);
    wr(A_DEN, 32'h5555_00FF);
    chk_reg("R11 den", A_DEN, 32'h0000_00FF);
    wr(A_DEN, 0);
    wr(A_THI, 32'hFFFF_FFFF);
    chk_reg("R3 hi field", A_THI, 32'hFFFF_FFE0);
    wr(A_TLO, 32'hFFFF_FFFF);
    chk_reg("R3 lo field", A_TLO, LO_MAX);

    // R3 carry, R5 wrap onto alarm 0
    wr(A_ALM, 0);
    wr(A_STAT, 1);
    wr(A_THI, 32'd5 << 5);
    wr(A_TLO, LO_MAX - 2);
    wr(A_NUM, 1);
    wr(A_DEN, 1);
    run(5);
    chk_reg("R3 lo after wrap", A_TLO, 2);
    chk_reg("R3 hi carry", A_THI, 32'd6 << 5);
    chk_reg("R5 wrap onto zero alarm", A_STAT, 1);

    // R9 time write overrides the increment
    wr(A_TLO, 50);
    chk_reg("R9 load exact", A_TLO, 50);
    run(1);
    chk_reg("R9 resumes", A_TLO, 51);

    // R10 rate write clears the accumulator and holds the count
    wr(A_DEN, 0);
    wr(A_TLO, 0);
    wr(A_NUM, 1);
    wr(A_DEN, 2);
    run(3);
    chk_reg("R10 before", A_TLO, 1);
    wr(A_DEN, 2);
    chk_reg("R10 no advance on write", A_TLO, 1);
    run(1);
    chk_reg("R10 accumulator cleared", A_TLO, 1);
    run(1);
    chk_reg("R10 then steps", A_TLO, 2);

    // R5 exact crossing, R6 sticky and clear
    wr(A_DEN, 0);
    wr(A_STAT, 1);
    wr(A_IEN, 1);
    wr(A_ALM, 100);
    wr(A_TLO, 90);
    wr(A_THI, 0);
    wr(A_NUM, 1);
    wr(A_DEN, 1);
    run(9);
    chk("R5 not yet at 99", {31'd0, irq}, 0);
    run(1);
    chk("R5 fires at alarm", {31'd0, irq}, 1);
    run(20);
    chk("R6 sticky", {31'd0, irq}, 1);
    wr(A_STAT, 1);
    chk("R6 write-1 clears", {31'd0, irq}, 0);
    run(20);
    chk("R5 once per crossing", {31'd0, irq}, 0);

    // R5 multi-unit step jumps over the alarm
    wr(A_DEN, 0);
    wr(A_TLO, 95);
    wr(A_NUM, 7);
    wr(A_DEN, 1);
    run(1);
    chk_reg("R5 jump lo", A_TLO, 102);
    chk("R5 jump fires", {31'd0, irq}, 1);

    // R5 wrap past a nonzero alarm
    wr(A_DEN, 0);
    wr(A_STAT, 1);
    wr(A_ALM, 2);
    wr(A_TLO, LO_MAX - 1);
    wr(A_NUM, 3);
    wr(A_DEN, 1);
    run(1);
    chk("R5 wrap below alarm", {31'd0, irq}, 0);
    run(1);
    chk("R5 wrap then cross", {31'd0, irq}, 1);

    // R12 high word ignored by the comparison
    wr(A_DEN, 0);
    wr(A_STAT, 1);
    wr(A_ALM, 10);
    wr(A_TLO, 5);
    wr(A_THI, 32'hFFFF_FFE0);
    run(5);
    chk_reg("R12 high word no event", A_STAT, 0);

    // R8 status latched while disabled, irq follows enable
    wr(A_IEN, 0);
    wr(A_ALM, 100);
    wr(A_TLO, 99);
    wr(A_NUM, 1);
    wr(A_DEN, 1);
    run(1);
    chk("R8 masked irq", {31'd0, irq}, 0);
    chk_reg("R8 status latched", A_STAT, 1);
    wr(A_IEN, 1);
    chk("R8 irq on enable", {31'd0, irq}, 1);

    // R7 clear and event on the same edge
    wr(A_DEN, 0);
    wr(A_TLO, 99);
    wr(A_NUM, 1);
    wr(A_DEN, 1);
    wr(A_STAT, 1);
    chk_reg("R7 lo at alarm", A_TLO, 100);
    chk_reg("R7 event beats clear", A_STAT, 1);

    summary();
    $finish;
  end
endmodule